// File: doc/BRIEF.md
# Three-Bus Processor Datapath

This block is the data side of a small processor in which three internal buses carry operands and results. A two-read, one-write register file places two registers on buses A and B in the same cycle. An ALU takes its first operand from a selector that picks bus A or the constant 4, and its second operand from bus B. It drives its result onto bus C, from which the register file, PC, MAR, MDR and IR can all be loaded. A dedicated incrementer moves the PC forward by 4 without involving the ALU. Because the ALU can forward either operand unchanged and both sources are available at once, no temporary holding registers are needed. An instruction fetch followed by a three-operand add completes in four control steps.

The block holds no sequencing of its own. An external control unit supplies a set of control signals every cycle. A memory model answers read and write strobes with a memory-function-complete pulse. The architectural registers can be observed on the outputs, and register-file contents can be seen by selecting them onto bus A or B.

Top module: `tribus_datapath`

## Requirements
- R1: A synchronous reset clears PC, MAR, MDR, IR, every register-file entry, and both pending memory strobes to zero.
- R2: Bus A shows the register selected by `a_sel_i`, and bus B shows the register selected by `b_sel_i` when `b_src_i`=0, both combinationally in the same cycle.
- R3: When `c_we_i` is high, the register selected by `c_sel_i` loads bus C at the rising edge. A read of that register in the same cycle still shows the old value.
- R4: When `a_const4_i`=1 the ALU first operand is the constant 4; when it is 0 the first operand is bus A.
- R5: ALU codes on `alu_op_i`: 0 forward first operand, 1 forward bus B, 2 add, 3 subtract (first minus B), 4 AND, 5 OR, 6 XOR, 7 gives zero. The result appears combinationally on bus C.
- R6: With `inc_pc_i` the PC advances by 4 modulo 2^32. With `pc_ld_i` the PC loads bus C, and this takes priority over the increment.
- R7: MAR loads bus C when `mar_ld_i` is high, and IR loads bus C when `ir_ld_i` is high. Otherwise each holds its value.
- R8: `rd_i` (or `wr_i`) raises `mem_rd_o` (or `mem_wr_o`) from the next cycle until the edge at which `mfc_i` is seen. When `mfc_i` arrives while a read is pending, MDR loads `mem_rdata_i`. When nothing is pending, `mfc_i` has no effect on MDR.
- R9: MDR loads bus C when `mdr_ld_i` is high. A read completion in the same cycle wins over `mdr_ld_i`.
- R10: Bus B source codes on `b_src_i`: 0 register port B, 1 PC, 2 MDR, 3 zero.
- R11: The sequence fetch (PC to MAR with read and increment), wait for completion, MDR to IR, then one add step with register sources on A and B and the destination loaded from C, leaves the fetched word in IR, PC+4 in PC and the sum in the destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, all loads on rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| a_sel_i | input | 3 | Register placed on bus A |
| b_sel_i | input | 3 | Register placed on bus B when b_src_i=0 |
| b_src_i | input | 2 | Bus B source select |
| a_const4_i | input | 1 | ALU first operand is constant 4 |
| alu_op_i | input | 3 | ALU function |
| c_sel_i | input | 3 | Register written from bus C |
| c_we_i | input | 1 | Register file write enable |
| pc_ld_i | input | 1 | Load PC from bus C |
| inc_pc_i | input | 1 | Advance PC by 4 |
| mar_ld_i | input | 1 | Load MAR from bus C |
| mdr_ld_i | input | 1 | Load MDR from bus C |
| ir_ld_i | input | 1 | Load IR from bus C |
| rd_i | input | 1 | Start memory read |
| wr_i | input | 1 | Start memory write |
| mfc_i | input | 1 | Memory function complete |
| mem_rdata_i | input | 32 | Memory read data |
| mem_addr_o | output | 32 | MAR contents |
| mem_wdata_o | output | 32 | MDR contents |
| mem_rd_o | output | 1 | Read pending |
| mem_wr_o | output | 1 | Write pending |
| pc_o | output | 32 | PC contents |
| ir_o | output | 32 | IR contents |
| bus_a_o | output | 32 | Bus A value |
| bus_b_o | output | 32 | Bus B value |
| bus_c_o | output | 32 | Bus C value |

## Verification
Bus A, bus B and bus C are combinational, so their checks are made one time unit after the control inputs change, with no clock edge in between. Every register load (PC, MAR, MDR, IR, register file, pending strobes) is due at the first rising edge after its enable. The bench therefore drives each step just after a falling edge and samples the registered outputs at the next falling edge. The read-during-write case is checked both before and after the single edge that separates old from new.

// File: rtl/tribus_pkg.sv
package tribus_pkg;

    typedef enum logic [2:0] {
        ALU_FWD_A = 3'd0,
        ALU_FWD_B = 3'd1,
        ALU_ADD   = 3'd2,
        ALU_SUB   = 3'd3,
        ALU_AND   = 3'd4,
        ALU_OR    = 3'd5,
        ALU_XOR   = 3'd6,
        ALU_NONE  = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        BSRC_REG  = 2'd0,
        BSRC_PC   = 2'd1,
        BSRC_MDR  = 2'd2,
        BSRC_ZERO = 2'd3
    } bsrc_e;

endpackage

// File: rtl/tribus_regfile.sv
module tribus_regfile #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned NREGS = 8,
    localparam int unsigned IW   = $clog2(NREGS)
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [IW-1:0]   ra_sel_i,
    input  logic [IW-1:0]   rb_sel_i,
    input  logic [IW-1:0]   w_sel_i,
    input  logic            w_en_i,
    input  logic [XLEN-1:0] w_data_i,
    output logic [XLEN-1:0] ra_data_o,
    output logic [XLEN-1:0] rb_data_o
);

    logic [XLEN-1:0] regs_d [NREGS];
    logic [XLEN-1:0] regs_q [NREGS];

    // Per-entry next value; each entry compares against its own index.
    for (genvar g = 0; g < NREGS; g++) begin : g_entry
        always_comb begin
            regs_d[g] = regs_q[g];
            if (w_en_i && (w_sel_i == IW'(g))) begin
                regs_d[g] = w_data_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        for (int i = 0; i < NREGS; i++) begin
            if (rst_i) regs_q[i] <= '0;
            else       regs_q[i] <= regs_d[i];
        end
    end

    // Reads come from the stored state, so a same-cycle write is not seen.
    assign ra_data_o = regs_q[ra_sel_i];
    assign rb_data_o = regs_q[rb_sel_i];

endmodule

// File: rtl/tribus_alu.sv
module tribus_alu
    import tribus_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [2:0]      op_i,
    input  logic            use_const_i,
    input  logic [XLEN-1:0] bus_a_i,
    input  logic [XLEN-1:0] bus_b_i,
    output logic [XLEN-1:0] res_o
);

    localparam logic [XLEN-1:0] CONST_STEP = XLEN'(4);

    logic [XLEN-1:0] opa;

    always_comb begin
        opa = use_const_i ? CONST_STEP : bus_a_i;
        unique case (alu_op_e'(op_i))
            ALU_FWD_A: res_o = opa;
            ALU_FWD_B: res_o = bus_b_i;
            ALU_ADD:   res_o = opa + bus_b_i;
            ALU_SUB:   res_o = opa - bus_b_i;
            ALU_AND:   res_o = opa & bus_b_i;
            ALU_OR:    res_o = opa | bus_b_i;
            ALU_XOR:   res_o = opa ^ bus_b_i;
            default:   res_o = '0;
        endcase
    end

endmodule

// File: rtl/tribus_pc_step.sv
module tribus_pc_step #(
    parameter int unsigned XLEN = 32,
    parameter int unsigned STEP = 4
) (
    input  logic [XLEN-1:0] pc_i,
    output logic [XLEN-1:0] pc_next_o
);

    assign pc_next_o = pc_i + XLEN'(STEP);

endmodule

// File: rtl/tribus_datapath.sv
module tribus_datapath
    import tribus_pkg::*;
#(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned NREGS = 8,
    localparam int unsigned IW   = $clog2(NREGS)
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [IW-1:0]   a_sel_i,
    input  logic [IW-1:0]   b_sel_i,
    input  logic [1:0]      b_src_i,
    input  logic            a_const4_i,
    input  logic [2:0]      alu_op_i,
    input  logic [IW-1:0]   c_sel_i,
    input  logic            c_we_i,
    input  logic            pc_ld_i,
    input  logic            inc_pc_i,
    input  logic            mar_ld_i,
    input  logic            mdr_ld_i,
    input  logic            ir_ld_i,
    input  logic            rd_i,
    input  logic            wr_i,
    input  logic            mfc_i,
    input  logic [XLEN-1:0] mem_rdata_i,
    output logic [XLEN-1:0] mem_addr_o,
    output logic [XLEN-1:0] mem_wdata_o,
    output logic            mem_rd_o,
    output logic            mem_wr_o,
    output logic [XLEN-1:0] pc_o,
    output logic [XLEN-1:0] ir_o,
    output logic [XLEN-1:0] bus_a_o,
    output logic [XLEN-1:0] bus_b_o,
    output logic [XLEN-1:0] bus_c_o
);

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] mar;
        logic [XLEN-1:0] mdr;
        logic [XLEN-1:0] ir;
        logic            rd_pend;
        logic            wr_pend;
    } dp_state_t;

    dp_state_t st_d, st_q;

    logic [XLEN-1:0] rf_a, rf_b;
    logic [XLEN-1:0] bus_b, bus_c;
    logic [XLEN-1:0] pc_plus;

    tribus_regfile #(.XLEN(XLEN), .NREGS(NREGS)) i_rf (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .ra_sel_i  (a_sel_i),
        .rb_sel_i  (b_sel_i),
        .w_sel_i   (c_sel_i),
        .w_en_i    (c_we_i),
        .w_data_i  (bus_c),
        .ra_data_o (rf_a),
        .rb_data_o (rf_b)
    );

    always_comb begin
        unique case (bsrc_e'(b_src_i))
            BSRC_REG: bus_b = rf_b;
            BSRC_PC:  bus_b = st_q.pc;
            BSRC_MDR: bus_b = st_q.mdr;
            default:  bus_b = '0;
        endcase
    end

    tribus_alu #(.XLEN(XLEN)) i_alu (
        .op_i        (alu_op_i),
        .use_const_i (a_const4_i),
        .bus_a_i     (rf_a),
        .bus_b_i     (bus_b),
        .res_o       (bus_c)
    );

    tribus_pc_step #(.XLEN(XLEN), .STEP(4)) i_pcinc (
        .pc_i      (st_q.pc),
        .pc_next_o (pc_plus)
    );

    always_comb begin
        st_d = st_q;
        if (pc_ld_i)       st_d.pc = bus_c;
        else if (inc_pc_i) st_d.pc = pc_plus;
        if (mar_ld_i)      st_d.mar = bus_c;
        if (ir_ld_i)       st_d.ir  = bus_c;
        if (mfc_i && st_q.rd_pend) st_d.mdr = mem_rdata_i;
        else if (mdr_ld_i)         st_d.mdr = bus_c;
        st_d.rd_pend = rd_i | (st_q.rd_pend & ~mfc_i);
        st_d.wr_pend = wr_i | (st_q.wr_pend & ~mfc_i);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign mem_addr_o  = st_q.mar;
    assign mem_wdata_o = st_q.mdr;
    assign mem_rd_o    = st_q.rd_pend;
    assign mem_wr_o    = st_q.wr_pend;
    assign pc_o        = st_q.pc;
    assign ir_o        = st_q.ir;
    assign bus_a_o     = rf_a;
    assign bus_b_o     = bus_b;
    assign bus_c_o     = bus_c;

endmodule

// File: rtl/tribus_checker.sv
module tribus_checker
    import tribus_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input logic            clk_i,
    input logic            rst_i,
    input logic [2:0]      alu_op_i,
    input logic            pc_ld_i,
    input logic            inc_pc_i,
    input logic            mar_ld_i,
    input logic            ir_ld_i,
    input logic            mfc_i,
    input logic [XLEN-1:0] mem_rdata_i,
    input logic [XLEN-1:0] mem_addr_o,
    input logic [XLEN-1:0] mem_wdata_o,
    input logic            mem_rd_o,
    input logic [XLEN-1:0] pc_o,
    input logic [XLEN-1:0] ir_o,
    input logic [XLEN-1:0] bus_b_o,
    input logic [XLEN-1:0] bus_c_o
);

    AST_PC_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        (inc_pc_i && !pc_ld_i) |=> (pc_o == $past(pc_o) + XLEN'(4))); // R6

    AST_PC_LOAD: assert property (@(posedge clk_i) disable iff (rst_i)
        pc_ld_i |=> (pc_o == $past(bus_c_o))); // R6

    AST_MAR_LOAD: assert property (@(posedge clk_i) disable iff (rst_i)
        mar_ld_i |=> (mem_addr_o == $past(bus_c_o))); // R7

    AST_IR_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !ir_ld_i |=> $stable(ir_o)); // R7

    AST_READ_DONE: assert property (@(posedge clk_i) disable iff (rst_i)
        (mem_rd_o && mfc_i) |=> (mem_wdata_o == $past(mem_rdata_i))); // R8

    AST_FWD_B: assert property (@(posedge clk_i) disable iff (rst_i)
        (alu_op_i == ALU_FWD_B) |-> (bus_c_o == bus_b_o)); // R5

endmodule

bind tribus_datapath tribus_checker #(.XLEN(XLEN)) i_tribus_checker (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .alu_op_i    (alu_op_i),
    .pc_ld_i     (pc_ld_i),
    .inc_pc_i    (inc_pc_i),
    .mar_ld_i    (mar_ld_i),
    .ir_ld_i     (ir_ld_i),
    .mfc_i       (mfc_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rd_o    (mem_rd_o),
    .pc_o        (pc_o),
    .ir_o        (ir_o),
    .bus_b_o     (bus_b_o),
    .bus_c_o     (bus_c_o)
);

// File: tb/test_tribus_datapath.sv
`timescale 1ns/1ps
module test_tribus_datapath;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  a_sel, b_sel, c_sel, alu_op;
    logic [1:0]  b_src;
    logic        a_const4, c_we, pc_ld, inc_pc, mar_ld, mdr_ld, ir_ld;
    logic        rd, wr, mfc;
    logic [31:0] mem_rdata;
    logic [31:0] mem_addr, mem_wdata, pc, ir, bus_a, bus_b, bus_c;
    logic        mem_rd, mem_wr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tribus_datapath i_tribus_datapath (
        .clk_i(clk), .rst_i(rst),
        .a_sel_i(a_sel), .b_sel_i(b_sel), .b_src_i(b_src),
        .a_const4_i(a_const4), .alu_op_i(alu_op),
        .c_sel_i(c_sel), .c_we_i(c_we),
        .pc_ld_i(pc_ld), .inc_pc_i(inc_pc),
        .mar_ld_i(mar_ld), .mdr_ld_i(mdr_ld), .ir_ld_i(ir_ld),
        .rd_i(rd), .wr_i(wr), .mfc_i(mfc), .mem_rdata_i(mem_rdata),
        .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
        .pc_o(pc), .ir_o(ir),
        .bus_a_o(bus_a), .bus_b_o(bus_b), .bus_c_o(bus_c)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        a_sel = 0; b_sel = 0; c_sel = 0; alu_op = 0; b_src = 0;
        a_const4 = 0; c_we = 0; pc_ld = 0; inc_pc = 0;
        mar_ld = 0; mdr_ld = 0; ir_ld = 0; rd = 0; wr = 0; mfc = 0;
        mem_rdata = 0;
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Load a register through a memory read, MDR, bus B and ALU forward-B.
    task automatic load_reg(input logic [2:0] idx, input logic [31:0] val);
        idle(); rd = 1; cyc();
        idle(); mfc = 1; mem_rdata = val; cyc();
        idle(); b_src = 2'd2; alu_op = 3'd1; c_we = 1; c_sel = idx; cyc();
        idle();
    endtask

    task automatic peek(input logic [2:0] idx, output logic [31:0] val);
        idle(); a_sel = idx; #1; val = bus_a;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 pc", pc, 0);
        check("R1 ir", ir, 0);
        check("R1 mar", mem_addr, 0);
        check("R1 mdr", mem_wdata, 0);
        check("R1 strobes", {30'd0, mem_rd, mem_wr}, 0);
        peek(3'd5, v);
        check("R1 reg5", v, 0);
    endtask

    task automatic t_fetch_add();
        logic [31:0] v;
        load_reg(3'd4, 32'h0000_1111);
        load_reg(3'd5, 32'h2222_0003);
        // step 1: PC -> B -> C -> MAR, read, increment
        idle(); b_src = 2'd1; alu_op = 3'd1; mar_ld = 1; rd = 1; inc_pc = 1; cyc();
        check("R11 mar=oldpc", mem_addr, 32'd0);
        check("R11 pc+4", pc, 32'd4);
        check("R8 rd pending", {31'd0, mem_rd}, 1);
        // step 2: wait for completion, one idle cycle first
        idle(); cyc();
        check("R8 rd held", {31'd0, mem_rd}, 1);
        idle(); mfc = 1; mem_rdata = 32'hCAFE_0123; cyc();
        check("R8 rd cleared", {31'd0, mem_rd}, 0);
        check("R8 mdr from mem", mem_wdata, 32'hCAFE_0123);
        // step 3: MDR -> B -> C -> IR
        idle(); b_src = 2'd2; alu_op = 3'd1; ir_ld = 1; cyc();
        check("R11 ir", ir, 32'hCAFE_0123);
        // step 4: r6 = r4 + r5
        idle(); a_sel = 3'd4; b_sel = 3'd5; b_src = 2'd0; alu_op = 3'd2;
        c_we = 1; c_sel = 3'd6; cyc();
        peek(3'd6, v);
        check("R11 add result", v, 32'h2222_1114);
    endtask

    task automatic t_ports();
        load_reg(3'd1, 32'h0000_1234);
        load_reg(3'd2, 32'hFFFF_0001);
        idle(); a_sel = 3'd1; b_sel = 3'd2; #1;
        check("R2 bus A", bus_a, 32'h0000_1234);
        check("R2 bus B", bus_b, 32'hFFFF_0001);
        check("R10 reg source", bus_b, 32'hFFFF_0001);
    endtask

    task automatic t_alu();
        logic [31:0] a, b;
        a = 32'h0000_1234; b = 32'hFFFF_0001;
        for (int op = 0; op < 8; op++) begin
            logic [31:0] exp;
            idle(); a_sel = 3'd1; b_sel = 3'd2; alu_op = 3'(op); #1;
            case (op)
                0: exp = a;      1: exp = b;
                2: exp = a + b;  3: exp = a - b;
                4: exp = a & b;  5: exp = a | b;
                6: exp = a ^ b;  default: exp = 0;
            endcase
            check($sformatf("R5 op%0d", op), bus_c, exp);
        end
        idle(); a_sel = 3'd1; b_sel = 3'd2; a_const4 = 1; alu_op = 3'd2; #1;
        check("R4 const4 add", bus_c, b + 32'd4);
        alu_op = 3'd0; #1;
        check("R4 const4 fwd", bus_c, 32'd4);
        a_const4 = 0; #1;
        check("R4 bus A fwd", bus_c, a);
    endtask

    task automatic t_rw_same();
        logic [31:0] v;
        load_reg(3'd3, 32'h0000_A5A5);
        idle(); a_sel = 3'd3; a_const4 = 1; alu_op = 3'd0; c_we = 1; c_sel = 3'd3; #1;
        check("R3 old value same cycle", bus_a, 32'h0000_A5A5);
        cyc();
        peek(3'd3, v);
        check("R3 new value after edge", v, 32'd4);
    endtask

    task automatic t_pc();
        load_reg(3'd7, 32'hFFFF_FFFC);
        idle(); a_sel = 3'd7; alu_op = 3'd0; pc_ld = 1; cyc();
        check("R6 pc load", pc, 32'hFFFF_FFFC);
        idle(); inc_pc = 1; cyc();
        check("R6 pc wrap", pc, 32'd0);
        idle(); a_sel = 3'd7; alu_op = 3'd0; pc_ld = 1; inc_pc = 1; cyc();
        check("R6 load over inc", pc, 32'hFFFF_FFFC);
        idle(); b_src = 2'd1; #1;
        check("R10 pc source", bus_b, 32'hFFFF_FFFC);
        b_src = 2'd3; alu_op = 3'd1; #1;
        check("R10 zero source", bus_c, 32'd0);
    endtask

    task automatic t_regs_misc();
        logic [31:0] ir0;
        ir0 = ir;
        idle(); a_const4 = 1; alu_op = 3'd0; mar_ld = 1; cyc();
        check("R7 mar load", mem_addr, 32'd4);
        idle(); a_sel = 3'd7; alu_op = 3'd0; cyc();
        check("R7 ir hold", ir, ir0);
        check("R7 mar hold", mem_addr, 32'd4);
        idle(); a_sel = 3'd7; alu_op = 3'd0; ir_ld = 1; cyc();
        check("R7 ir load", ir, 32'hFFFF_FFFC);
    endtask

    task automatic t_mem();
        idle(); a_const4 = 1; alu_op = 3'd0; mdr_ld = 1; cyc();
        check("R9 mdr from bus C", mem_wdata, 32'd4);
        idle(); mfc = 1; mem_rdata = 32'hDEAD_BEEF; cyc();
        check("R8 stray mfc ignored", mem_wdata, 32'd4);
        idle(); wr = 1; cyc();
        check("R8 wr pending", {30'd0, mem_rd, mem_wr}, 32'd1);
        idle(); cyc();
        check("R8 wr held", {31'd0, mem_wr}, 1);
        idle(); mfc = 1; cyc();
        check("R8 wr cleared", {31'd0, mem_wr}, 0);
        check("R8 write keeps mdr", mem_wdata, 32'd4);
        idle(); rd = 1; cyc();
        idle(); mfc = 1; mem_rdata = 32'h0000_0077; a_const4 = 1; alu_op = 3'd0; mdr_ld = 1; cyc();
        check("R9 read completion wins", mem_wdata, 32'h0000_0077);
        idle();
    endtask

    task automatic t_reset_again();
        logic [31:0] v;
        idle(); rst = 1; cyc(); rst = 0;
        check("R1 pc after reset", pc, 0);
        check("R1 ir after reset", ir, 0);
        peek(3'd6, v);
        check("R1 reg6 after reset", v, 0);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1;
        @(negedge clk); @(negedge clk);
        rst = 0;
        t_reset();
        t_fetch_add();
        t_ports();
        t_alu();
        t_rw_same();
        t_pc();
        t_regs_misc();
        t_mem();
        t_reset_again();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule